// File: doc/BRIEF.md
# Multi-Channel Programmable Interval Timer

A memory-mapped timer peripheral on an APB-style bus with a parameterised number of channels (four by default). Each channel owns a control register, a reload register and a counter register. The counter register can be read and also written. Depending on its width mode, a channel's 32-bit counter acts as one 32-bit timer, as two independent 16-bit timers, or as four independent 8-bit timers.

Each enabled timer counts down by one on every count tick. After it has reached zero, the next tick reloads it from its slice of the reload register and flags an underflow. A timer with reload value R therefore raises an underflow every R+1 ticks. Every channel selects its own tick source: either every bus clock cycle, or each rising edge of a shared external clock input after that input has been synchronised.

The timer enables, interrupt enables and interrupt status bits for all timers sit in three shared registers, four bits per channel. A single interrupt line combines the status bits that are enabled. The bus side is plain APB-style control. Writes take effect on the access-phase edge, reads are combinational from the address while the slave is selected, and the slave never stalls the bus, so there is no back-pressure.

Top module: `qtimer_top`

## Requirements
- R1: Address 0x00 reads the fixed constant 0x51540100, and a write to it changes nothing. Address 0x10 is read-only and returns the channel count.
- R2: Channel c has its control register at 0x20+0x10*c, its reload register at 0x24+0x10*c and its counter register at 0x28+0x10*c. The interrupt enable register is at 0x14, the interrupt status register at 0x18 and the timer enable register at 0x1C. Timer t of channel c uses bit 4*c+t in each of the shared registers.
- R3: Control bits [2:0] select the mode. Value 1 gives one 32-bit timer, driven by enable bit t=0. Value 2 gives two 16-bit timers: t=0 uses bits [15:0] and t=1 uses bits [31:16]. Value 3 gives four 8-bit timers, where timer t uses byte t. Value 4 (PWM) and every other value leave the counter unchanged.
- R4: An enabled timer decrements on each tick. A tick that finds the timer at zero reloads the timer's reload slice instead of wrapping, and sets status bit 4*c+t. With reload R the underflow period is R+1 ticks.
- R5: The clock edge after a timer's enable bit goes from 0 to 1 loads that timer's slice of the counter from its reload slice, whatever the tick.
- R6: A bus write to a counter register presets the whole counter. It takes priority over loading and counting in the same cycle.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When an underflow and a clear of the same bit fall on the same edge, the bit stays set.
- R8: The interrupt output is high exactly when some status bit is set and its interrupt enable bit is set.
- R9: Control bit 3 selects the tick source: 1 means every bus clock cycle, 0 means the external clock. The external clock passes through a two-flop synchroniser, and each of its rising edges gives exactly one tick.
- R10: A timer whose enable bit is clear holds its slice of the counter, and so does an enable bit that has no timer in the current mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and count clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | AW (8) | Byte address |
| pwdata | input | DW (32) | Write data |
| prdata | output | DW (32) | Read data, valid while psel is high |
| ext_clk | input | 1 | Asynchronous external count clock |
| irq | output | 1 | Combined interrupt request |

## Verification
Two events can land on the same clock edge: a timer's underflow, which sets a status bit, and a software clear of that same bit. The bench arms a timer with reload 3 on the bus clock. It counts edges from the enable write and places the access phase of a write-one-to-clear exactly on the second underflow edge. It then reads the status register back and expects the bit to remain set. A second clear, placed two edges later where no underflow occurs, must read back as cleared, so the test can tell a set-wins merge from a clear that never took effect.

// File: rtl/qtimer_pkg.sv
package qtimer_pkg;

  localparam logic [31:0] QT_ID_VALUE = 32'h5154_0100;

  // shared register addresses
  localparam int ADDR_ID   = 'h00;
  localparam int ADDR_CFG  = 'h10;
  localparam int ADDR_IEN  = 'h14;
  localparam int ADDR_ISTA = 'h18;
  localparam int ADDR_CHEN = 'h1C;

  // per-channel register window
  localparam int CH_BASE   = 'h20;
  localparam int CH_STRIDE = 'h10;
  localparam int OFF_CTL   = 'h0;
  localparam int OFF_REL   = 'h4;
  localparam int OFF_CNT   = 'h8;

  localparam int TMR_PER_CH = 4;
  localparam int CTL_W      = 4;
  localparam int CTL_SRC    = 3;

  typedef enum logic [2:0] {
    MODE_OFF = 3'd0,
    MODE_W32 = 3'd1,
    MODE_W16 = 3'd2,
    MODE_W8  = 3'd3,
    MODE_PWM = 3'd4
  } mode_e;

endpackage

// File: rtl/qtimer_ext_sync.sv
module qtimer_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic tick
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_clk;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tick = s2_q & ~s3_q;
endmodule

// File: rtl/qtimer_chan.sv
module qtimer_chan
  import qtimer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ext_tick,
  input  logic                    ctl_we,
  input  logic                    rel_we,
  input  logic                    cnt_we,
  input  logic [DW-1:0]           wdata,
  input  logic [TMR_PER_CH-1:0]   en_i,
  output logic [CTL_W-1:0]        ctl_o,
  output logic [DW-1:0]           rel_o,
  output logic [DW-1:0]           cnt_o,
  output logic [TMR_PER_CH-1:0]   uf_o
);
  localparam int NVAR = 3;  // 32-, 16- and 8-bit splits

  logic [CTL_W-1:0]      ctl_q;
  logic [DW-1:0]         rel_q;
  logic [DW-1:0]         cnt_q;
  logic [TMR_PER_CH-1:0] en_q;
  logic [TMR_PER_CH-1:0] en_rise;
  logic                  tick;
  mode_e                 mode;

  logic [NVAR-1:0][DW-1:0]         var_nxt;
  logic [NVAR-1:0][TMR_PER_CH-1:0] var_uf;
  logic [DW-1:0]                   cnt_nxt;
  logic [TMR_PER_CH-1:0]           uf_sel;

  assign mode    = mode_e'(ctl_q[2:0]);
  assign tick    = ctl_q[CTL_SRC] | ext_tick;
  assign en_rise = en_i & ~en_q;

  // one next-state candidate per lane split; g picks 1, 2 or 4 lanes
  for (genvar g = 0; g < NVAR; g++) begin : g_split
    localparam int LANES = 1 << g;
    localparam int LW    = DW >> g;
    logic [DW-1:0]         nxt_l;
    logic [TMR_PER_CH-1:0] uf_l;

    always_comb begin
      nxt_l = cnt_q;
      uf_l  = '0;
      for (int l = 0; l < LANES; l++) begin
        if (en_rise[l]) begin
          nxt_l[l*LW +: LW] = rel_q[l*LW +: LW];
        end else if (en_i[l] && tick) begin
          if (cnt_q[l*LW +: LW] == '0) begin
            nxt_l[l*LW +: LW] = rel_q[l*LW +: LW];
            uf_l[l]           = 1'b1;
          end else begin
            nxt_l[l*LW +: LW] = cnt_q[l*LW +: LW] - LW'(1);
          end
        end
      end
    end

    assign var_nxt[g] = nxt_l;
    assign var_uf[g]  = uf_l;
  end

  always_comb begin
    case (mode)
      MODE_W32: begin cnt_nxt = var_nxt[0]; uf_sel = var_uf[0]; end
      MODE_W16: begin cnt_nxt = var_nxt[1]; uf_sel = var_uf[1]; end
      MODE_W8:  begin cnt_nxt = var_nxt[2]; uf_sel = var_uf[2]; end
      default:  begin cnt_nxt = cnt_q;      uf_sel = '0;        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rel_q <= '0;
      cnt_q <= '0;
      en_q  <= '0;
    end else begin
      en_q <= en_i;
      if (ctl_we) ctl_q <= wdata[CTL_W-1:0];
      if (rel_we) rel_q <= wdata;
      if (cnt_we) cnt_q <= wdata;
      else        cnt_q <= cnt_nxt;
    end
  end

  assign ctl_o = ctl_q;
  assign rel_o = rel_q;
  assign cnt_o = cnt_q;
  assign uf_o  = cnt_we ? '0 : uf_sel;
endmodule

// File: rtl/qtimer_irq.sv
module qtimer_irq #(
  parameter int NT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ien_we,
  input  logic          sta_we,
  input  logic [NT-1:0] wdata,
  input  logic [NT-1:0] uf,
  output logic [NT-1:0] ien_o,
  output logic [NT-1:0] sta_o,
  output logic          irq
);
  logic [NT-1:0] ien_q, sta_q, clr;

  assign clr = sta_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      sta_q <= '0;
    end else begin
      if (ien_we) ien_q <= wdata;
      sta_q <= (sta_q & ~clr) | uf;   // a fresh underflow outranks the clear
    end
  end

  assign ien_o = ien_q;
  assign sta_o = sta_q;
  assign irq   = |(sta_q & ien_q);
endmodule

// File: rtl/qtimer_top.sv
module qtimer_top #(
  parameter int NUM_CH = 4,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  input  logic          ext_clk,
  output logic          irq
);
  import qtimer_pkg::*;

  localparam int NT = NUM_CH * TMR_PER_CH;

  logic                                bus_wr;
  logic                                ext_tick;
  logic [NT-1:0]                       chen_q;
  logic [NT-1:0]                       ien_q;
  logic [NT-1:0]                       sta_q;
  logic [NT-1:0]                       uf_all;
  logic [NUM_CH-1:0][CTL_W-1:0]        ch_ctl;
  logic [NUM_CH-1:0][DW-1:0]           ch_rel;
  logic [NUM_CH-1:0][DW-1:0]           ch_cnt;
  logic [NUM_CH-1:0][TMR_PER_CH-1:0]   ch_uf;

  assign bus_wr = psel & penable & pwrite;

  qtimer_ext_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_clk (ext_clk),
    .tick    (ext_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  chen_q <= '0;
    else if (bus_wr && paddr == AW'(ADDR_CHEN))  chen_q <= pwdata[NT-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [AW-1:0] A_CTL = AW'(CH_BASE + CH_STRIDE*c + OFF_CTL);
    localparam logic [AW-1:0] A_REL = AW'(CH_BASE + CH_STRIDE*c + OFF_REL);
    localparam logic [AW-1:0] A_CNT = AW'(CH_BASE + CH_STRIDE*c + OFF_CNT);

    qtimer_chan #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_tick (ext_tick),
      .ctl_we   (bus_wr && paddr == A_CTL),
      .rel_we   (bus_wr && paddr == A_REL),
      .cnt_we   (bus_wr && paddr == A_CNT),
      .wdata    (pwdata),
      .en_i     (chen_q[c*TMR_PER_CH +: TMR_PER_CH]),
      .ctl_o    (ch_ctl[c]),
      .rel_o    (ch_rel[c]),
      .cnt_o    (ch_cnt[c]),
      .uf_o     (ch_uf[c])
    );

    assign uf_all[c*TMR_PER_CH +: TMR_PER_CH] = ch_uf[c];
  end

  qtimer_irq #(.NT(NT)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ien_we (bus_wr && paddr == AW'(ADDR_IEN)),
    .sta_we (bus_wr && paddr == AW'(ADDR_ISTA)),
    .wdata  (pwdata[NT-1:0]),
    .uf     (uf_all),
    .ien_o  (ien_q),
    .sta_o  (sta_q),
    .irq    (irq)
  );

  always_comb begin
    prdata = '0;
    if (psel) begin
      if      (paddr == AW'(ADDR_ID))   prdata = DW'(QT_ID_VALUE);
      else if (paddr == AW'(ADDR_CFG))  prdata = DW'(NUM_CH);
      else if (paddr == AW'(ADDR_IEN))  prdata = DW'(ien_q);
      else if (paddr == AW'(ADDR_ISTA)) prdata = DW'(sta_q);
      else if (paddr == AW'(ADDR_CHEN)) prdata = DW'(chen_q);
      else begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (paddr == AW'(CH_BASE + CH_STRIDE*c + OFF_CTL)) prdata = DW'(ch_ctl[c]);
          if (paddr == AW'(CH_BASE + CH_STRIDE*c + OFF_REL)) prdata = ch_rel[c];
          if (paddr == AW'(CH_BASE + CH_STRIDE*c + OFF_CNT)) prdata = ch_cnt[c];
        end
      end
    end
  end
endmodule

// File: rtl/qtimer_chk.sv
module qtimer_chk #(
  parameter int NT = 16,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] prdata,
  input logic          irq,
  input logic [NT-1:0] ien,
  input logic [NT-1:0] sta,
  input logic [NT-1:0] uf,
  input logic [NT-1:0] chen,
  input logic [DW-1:0] cnt0,
  input logic [DW-1:0] rel0,
  input logic [2:0]    mode0
);
  import qtimer_pkg::*;

  logic bus_wr, sta_wr;
  assign bus_wr = psel && penable && pwrite;
  assign sta_wr = bus_wr && paddr == AW'(ADDR_ISTA);

  assert_id_const_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && paddr == AW'(ADDR_ID)) |-> prdata == DW'(QT_ID_VALUE));

  assert_hold_off_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 != 3'd1 && mode0 != 3'd2 && mode0 != 3'd3 && !bus_wr) |=> $stable(cnt0));

  assert_uf_sets_sta_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|uf) |=> ((sta & $past(uf)) == $past(uf)));

  assert_load_on_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chen[0]) && mode0 == 3'd1 && !bus_wr) |=> cnt0 == $past(rel0));

  assert_sta_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sta_wr |=> (($past(sta) & ~sta) == '0));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

bind qtimer_top qtimer_chk #(.NT(NUM_CH*4), .AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .prdata  (prdata),
  .irq     (irq),
  .ien     (ien_q),
  .sta     (sta_q),
  .uf      (uf_all),
  .chen    (chen_q),
  .cnt0    (ch_cnt[0]),
  .rel0    (ch_rel[0]),
  .mode0   (ch_ctl[0][2:0])
);

// File: tb/tb_qtimer_top.sv
module tb_qtimer_top;
  localparam logic [7:0] A_ID = 8'h00, A_CFG = 8'h10, A_IEN = 8'h14,
                         A_STA = 8'h18, A_CHEN = 8'h1C;
  localparam logic [7:0] C0_CTL = 8'h20, C0_REL = 8'h24, C0_CNT = 8'h28;
  localparam logic [7:0] C1_CTL = 8'h30, C1_REL = 8'h34, C1_CNT = 8'h38;
  localparam logic [7:0] C2_CTL = 8'h40, C2_REL = 8'h44, C2_CNT = 8'h48;

  typedef struct packed {
    logic [2:0]  mode;
    logic [3:0]  mask;
    logic [7:0]  steps;
    logic [31:0] rel;
    logic [31:0] exp;
  } row_t;

  // channel 1, bus-clock ticks; steps-1 ticks after the load edge
  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{3'd1, 4'h1, 8'd1, 32'h0000_0010, 32'h0000_0010},
    '{3'd1, 4'h1, 8'd6, 32'h0000_0010, 32'h0000_000B},
    '{3'd1, 4'h1, 8'd6, 32'h0000_0003, 32'h0000_0002},
    '{3'd2, 4'h3, 8'd4, 32'h0005_0002, 32'h0002_0002},
    '{3'd2, 4'h2, 8'd4, 32'h0005_0002, 32'h0002_0000},
    '{3'd3, 4'hF, 8'd5, 32'h0403_0201, 32'h0003_0101},
    '{3'd3, 4'h5, 8'd3, 32'h0403_0201, 32'h0001_0001},
    '{3'd4, 4'h1, 8'd5, 32'h0000_0010, 32'h0000_0000},
    '{3'd1, 4'h2, 8'd5, 32'h0000_0010, 32'h0000_0000},
    '{3'd1, 4'h1, 8'd4, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n, psel, penable, pwrite, ext_clk;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        irq;
  int          n_cmp = 0, n_bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  qtimer_top dut (
    .clk (clk), .rst_n (rst_n), .psel (psel), .penable (penable),
    .pwrite (pwrite), .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
    .ext_clk (ext_clk), .irq (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; access edge is the second posedge; returns at a negedge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  initial begin
    logic [31:0] v, v2;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    peek(A_STA, v);  check("R7 reset status", v, 32'h0);
    peek(A_CHEN, v); check("R10 reset enables", v, 32'h0);
    peek(C0_CNT, v); check("R6 reset counter", v, 32'h0);
    check("R8 reset irq", {31'h0, irq}, 32'h0);

    // R1 identification and configuration
    peek(A_ID, v);  check("R1 id value", v, 32'h5154_0100);
    bus_wr(A_ID, 32'hFFFF_FFFF);
    peek(A_ID, v);  check("R1 id write ignored", v, 32'h5154_0100);
    peek(A_CFG, v); check("R1 channel count", v, 32'd4);

    // table walk on channel 1 (R2 addressing, R3 modes, R4 counting, R10 holds)
    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      r = ROWS[i];
      bus_wr(A_CHEN, 32'h0);
      bus_wr(C1_CNT, 32'h0);
      bus_wr(C1_REL, r.rel);
      bus_wr(C1_CTL, {28'h0, 1'b1, r.mode});
      bus_wr(A_CHEN, {24'h0, r.mask, 4'h0});
      repeat (r.steps) @(negedge clk);
      peek(C1_CNT, v);
      check($sformatf("R2 R3 R4 R5 R10 table row %0d", i), v, r.exp);
    end

    // R4 underflow sets status, R8 masking, R7 coincident set and clear
    bus_wr(A_CHEN, 32'h0);
    bus_wr(A_IEN, 32'h0);
    bus_wr(A_STA, 32'hFFFF_FFFF);
    bus_wr(C0_CTL, 32'h9);
    bus_wr(C0_REL, 32'h3);
    bus_wr(A_CHEN, 32'h1);
    repeat (7) @(negedge clk);
    peek(A_STA, v);  check("R4 underflow sets status", v & 32'h1, 32'h1);
    check("R8 irq masked", {31'h0, irq}, 32'h0);
    bus_wr(A_IEN, 32'h1);
    check("R8 irq asserted", {31'h0, irq}, 32'h1);

    bus_wr(A_CHEN, 32'h0);
    bus_wr(A_STA, 32'h1);
    bus_wr(A_CHEN, 32'h1);
    repeat (7) @(negedge clk);
    bus_wr(A_STA, 32'h1);   // lands on the second underflow edge
    peek(A_STA, v);  check("R7 set wins over clear", v & 32'h1, 32'h1);
    bus_wr(A_STA, 32'h1);   // two edges later, no underflow
    peek(A_STA, v);  check("R7 clear between underflows", v & 32'h1, 32'h0);
    bus_wr(A_CHEN, 32'h0);
    repeat (6) @(negedge clk);
    peek(A_STA, v);
    bus_wr(A_STA, 32'h0);
    peek(A_STA, v2); check("R7 write zero keeps bit", v2, v);
    bus_wr(A_STA, 32'hFFFF_FFFF);
    peek(A_STA, v);  check("R7 clear all", v, 32'h0);
    check("R8 irq drops", {31'h0, irq}, 32'h0);

    // R6 preset while counting, R10 hold when disabled
    bus_wr(C0_REL, 32'h100);
    bus_wr(A_CHEN, 32'h1);
    bus_wr(C0_CNT, 32'h50);
    peek(C0_CNT, v); check("R6 preset value", v, 32'h50);
    repeat (3) @(negedge clk);
    peek(C0_CNT, v); check("R6 counts from preset", v, 32'h4D);
    bus_wr(A_CHEN, 32'h0);
    peek(C0_CNT, v);
    repeat (5) @(negedge clk);
    peek(C0_CNT, v2); check("R10 disabled holds", v2, v);

    // R9 external clock ticks on channel 2
    bus_wr(C2_CNT, 32'h0);
    bus_wr(C2_REL, 32'h20);
    bus_wr(C2_CTL, 32'h1);
    bus_wr(A_CHEN, 32'h100);
    repeat (6) @(negedge clk);
    peek(C2_CNT, v); check("R9 no ext edge no tick", v, 32'h20);
    for (int k = 0; k < 5; k++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    peek(C2_CNT, v); check("R9 one tick per ext edge", v, 32'h1B);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule